// File: doc/BRIEF.md
# Output RGB-to-YUV Color Matrix

This stage sits at the output of a display compositor and turns a stream of 8-bit-per-channel RGB pixels into YUV. Each output channel is formed from a programmable row of three signed multipliers and one signed offset. The twelve row values and a control word are written through a narrow register write port. Programmed values are held in a shadow bank and copied into the working bank only when a start-of-frame pixel enters the stage. A frame is therefore never converted with a mix of old and new values. While the enable bit of the working bank is clear, pixels leave the stage unchanged.

Pixels enter and leave on valid/ready streams. Each pixel carries a start-of-frame bit and an end-of-line bit, and both bits travel through the stage alongside the pixel data. The datapath has three register stages: products, then sum plus offset, then floor and clamp. All three stages advance together whenever the output register is empty or is being drained.

The register bank is controlled by a two-state machine:
- CB_SYNCED: the working bank matches the shadow bank. A write to a mapped address (the "write" transition) moves it to CB_PENDING.
- CB_PENDING: the shadow bank holds values that have not yet been applied. An accepted start-of-frame pixel with no mapped write in the same cycle (the "frame load" transition) copies the shadow bank into the working bank and returns to CB_SYNCED. If a mapped write arrives in the same cycle as that start-of-frame pixel, the copy still happens, using the shadow contents from before the write, and the machine stays in CB_PENDING.

Top module: `rgb2yuv_matrix`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, the enable bit is clear, and both banks hold the default matrix.
- R2: When out_ready is high, a pixel accepted on a rising edge is presented on the output after the second following rising edge (three register stages). in_ready is high whenever the output register is empty or out_ready is high.
- R3: While out_valid is high and out_ready is low, out_pix, out_sof and out_eol hold their values and in_ready is low. No pixel is lost or duplicated.
- R4: While the working enable bit is clear, out_pix equals in_pix exactly. Clearing the enable bit does not change the stored row values.
- R5: Pixels are packed as bits [23:16] = R (out: Y), [15:8] = G (out: U), [7:0] = B (out: V). Each output channel equals floor((m0*R + m1*G + m2*B + off*64) / 1024). Each m is 14-bit two's complement with 10 fractional bits. off is 14-bit two's complement with 4 fractional bits.
- R6: Each converted channel is clamped to the range 0..255.
- R7: The defaults are: Y row 0x107, 0x204, 0x064, offset 0x108; U row 0x3F69, 0x3ED6, 0x1C1, offset 0x808; V row 0x1C1, 0x3E88, 0x3FB8, offset 0x808. With these defaults white maps to (235,128,128) and black to (16,128,128).
- R8: Addresses 0..11 select the row values in row-major order: for each of Y, U and V in turn, multipliers for R, G, B, then the offset. Address 12 bit 0 is the enable bit. Writes to addresses 13..15 have no effect.
- R9: A write, to a row value or to the enable bit, takes effect starting with the next accepted start-of-frame pixel, and that pixel itself uses the new value. Earlier pixels use the old values.
- R10: out_sof and out_eol carry the in_sof and in_eol bits of the same pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 14 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can take a pixel |
| in_pix | input | 24 | Input RGB pixel |
| in_sof | input | 1 | Input start-of-frame |
| in_eol | input | 1 | Input end-of-line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take a pixel |
| out_pix | output | 24 | Output YUV (or bypassed RGB) pixel |
| out_sof | output | 1 | Output start-of-frame |
| out_eol | output | 1 | Output end-of-line |

## Verification
With out_ready held high, a converted pixel is due on the port at the third falling edge after the falling edge at which its input handshake was seen. The scoreboard stamps each queued item with that falling-edge count and checks the difference whenever no backpressure was applied during that phase. Under backpressure only order and value are compared, and a stalled output is rechecked one cycle later to confirm it held. Coefficient and enable changes are modelled in the bench as a shadow copy that moves into the working copy when the driver sends a start-of-frame pixel, which matches the frame-boundary timing of R9.

// File: rtl/rgb2yuv_pkg.sv
package rgb2yuv_pkg;

    localparam int NCH      = 3;
    localparam int NTERM    = 4;
    localparam int NREG     = NCH * NTERM;
    localparam int CTRL_IDX = NREG;
    localparam int CFG_AW   = 4;

    typedef enum logic [0:0] {
        CB_SYNCED  = 1'b0,
        CB_PENDING = 1'b1
    } cb_state_e;

    // Power-up matrix, row-major: Y, U, V; each row m_r, m_g, m_b, offset.
    function automatic logic [13:0] reset_coef(input int idx);
        case (idx)
            0:       return 14'h0107;
            1:       return 14'h0204;
            2:       return 14'h0064;
            3:       return 14'h0108;
            4:       return 14'h3F69;
            5:       return 14'h3ED6;
            6:       return 14'h01C1;
            7:       return 14'h0808;
            8:       return 14'h01C1;
            9:       return 14'h3E88;
            10:      return 14'h3FB8;
            11:      return 14'h0808;
            default: return 14'h0000;
        endcase
    endfunction

endpackage

// File: rtl/rgb2yuv_coef_bank.sv
module rgb2yuv_coef_bank
    import rgb2yuv_pkg::*;
#(
    parameter int COEF_W = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [COEF_W-1:0]        cfg_wdata,
    input  logic                     sof_take,
    output logic [NREG*COEF_W-1:0]   coef_act,
    output logic [NREG*COEF_W-1:0]   coef_use,
    output logic                     en_act,
    output logic                     en_use,
    output logic                     pending
);

    cb_state_e st_q, st_d;
    logic      hit;
    logic      load;
    logic      sh_en_q;
    logic      ac_en_q;

    assign hit = cfg_we && (cfg_addr <= CFG_AW'(CTRL_IDX));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CB_SYNCED;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CB_SYNCED:  st_d = hit ? CB_PENDING : CB_SYNCED;
            CB_PENDING: st_d = hit ? CB_PENDING :
                               (sof_take ? CB_SYNCED : CB_PENDING);
            default:    st_d = CB_SYNCED;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        load    = (st_q == CB_PENDING) && sof_take;
        pending = (st_q == CB_PENDING);
    end

    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_reg
            logic [COEF_W-1:0] sh_r;
            logic [COEF_W-1:0] ac_r;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_r <= COEF_W'($signed(reset_coef(i)));
                end else if (cfg_we && cfg_addr == CFG_AW'(i)) begin
                    sh_r <= cfg_wdata;
                end
            end
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ac_r <= COEF_W'($signed(reset_coef(i)));
                end else if (load) begin
                    ac_r <= sh_r;
                end
            end
            assign coef_act[i*COEF_W +: COEF_W] = ac_r;
            assign coef_use[i*COEF_W +: COEF_W] = load ? sh_r : ac_r;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_en_q <= 1'b0;
        end else if (cfg_we && cfg_addr == CFG_AW'(CTRL_IDX)) begin
            sh_en_q <= cfg_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    ac_en_q <= 1'b0;
        else if (load) ac_en_q <= sh_en_q;
    end

    assign en_act = ac_en_q;
    assign en_use = load ? sh_en_q : ac_en_q;

endmodule

// File: rtl/rgb2yuv_chan.sv
module rgb2yuv_chan
    import rgb2yuv_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int COEF_W   = 14,
    parameter int MUL_FRAC = 10,
    parameter int OFF_FRAC = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      adv,
    input  logic [NCH*PIX_W-1:0]      pix_in,
    input  logic [NTERM*COEF_W-1:0]   row,
    input  logic                      byp_in,
    input  logic [PIX_W-1:0]          pass_in,
    output logic [PIX_W-1:0]          res
);

    localparam int PROD_W = COEF_W + PIX_W + 1;
    localparam int SUM_W  = PROD_W + 3;
    localparam int SHIFT  = MUL_FRAC - OFF_FRAC;
    localparam logic signed [SUM_W-1:0] PMAX = SUM_W'((2 ** PIX_W) - 1);

    logic signed [PROD_W-1:0] p_q [NCH];
    logic signed [SUM_W-1:0]  off_q;
    logic signed [SUM_W-1:0]  sum_q;
    logic signed [SUM_W-1:0]  scaled;
    logic [PIX_W-1:0]         clip;
    logic [PIX_W-1:0]         pass1_q, pass2_q;
    logic                     byp1_q, byp2_q;

    // stage 1: products and scaled offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCH; k++) p_q[k] <= '0;
            off_q   <= '0;
            byp1_q  <= 1'b0;
            pass1_q <= '0;
        end else if (adv) begin
            for (int k = 0; k < NCH; k++) begin
                p_q[k] <= PROD_W'($signed(row[k*COEF_W +: COEF_W])) *
                          PROD_W'($signed({1'b0, pix_in[(NCH-1-k)*PIX_W +: PIX_W]}));
            end
            off_q   <= SUM_W'($signed(row[(NTERM-1)*COEF_W +: COEF_W])) <<< SHIFT;
            byp1_q  <= byp_in;
            pass1_q <= pass_in;
        end
    end

    // stage 2: sum with offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            byp2_q  <= 1'b0;
            pass2_q <= '0;
        end else if (adv) begin
            sum_q   <= SUM_W'(p_q[0]) + SUM_W'(p_q[1]) + SUM_W'(p_q[2]) + off_q;
            byp2_q  <= byp1_q;
            pass2_q <= pass1_q;
        end
    end

    // stage 3: floor, clamp, bypass select
    assign scaled = sum_q >>> MUL_FRAC;

    always_comb begin
        if (scaled[SUM_W-1])   clip = '0;
        else if (scaled > PMAX) clip = '1;
        else                   clip = scaled[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   res <= '0;
        else if (adv) res <= byp2_q ? pass2_q : clip;
    end

endmodule

// File: rtl/rgb2yuv_matrix.sv
module rgb2yuv_matrix
    import rgb2yuv_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int COEF_W   = 14,
    parameter int MUL_FRAC = 10,
    parameter int OFF_FRAC = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [COEF_W-1:0]     cfg_wdata,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [NCH*PIX_W-1:0]  in_pix,
    input  logic                  in_sof,
    input  logic                  in_eol,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [NCH*PIX_W-1:0]  out_pix,
    output logic                  out_sof,
    output logic                  out_eol
);

    localparam int DEPTH = 3;

    logic                    adv;
    logic                    in_take;
    logic                    sof_take;
    logic [NREG*COEF_W-1:0]  coef_act;
    logic [NREG*COEF_W-1:0]  coef_use;
    logic                    en_act;
    logic                    en_use;
    logic                    cfg_pending;
    logic [DEPTH-1:0]        vld_q;
    logic [DEPTH-1:0]        sof_q;
    logic [DEPTH-1:0]        eol_q;

    assign adv      = !vld_q[DEPTH-1] || out_ready;
    assign in_ready = adv;
    assign in_take  = in_valid && adv;
    assign sof_take = in_take && in_sof;

    rgb2yuv_coef_bank #(.COEF_W(COEF_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .sof_take  (sof_take),
        .coef_act  (coef_act),
        .coef_use  (coef_use),
        .en_act    (en_act),
        .en_use    (en_use),
        .pending   (cfg_pending)
    );

    // valid and sideband travel through the same three stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            sof_q <= '0;
            eol_q <= '0;
        end else if (adv) begin
            vld_q <= {vld_q[DEPTH-2:0], in_valid};
            sof_q <= {sof_q[DEPTH-2:0], in_sof};
            eol_q <= {eol_q[DEPTH-2:0], in_eol};
        end
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            rgb2yuv_chan #(
                .PIX_W    (PIX_W),
                .COEF_W   (COEF_W),
                .MUL_FRAC (MUL_FRAC),
                .OFF_FRAC (OFF_FRAC)
            ) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .adv     (adv),
                .pix_in  (in_pix),
                .row     (coef_use[c*NTERM*COEF_W +: NTERM*COEF_W]),
                .byp_in  (!en_use),
                .pass_in (in_pix[(NCH-1-c)*PIX_W +: PIX_W]),
                .res     (out_pix[(NCH-1-c)*PIX_W +: PIX_W])
            );
        end
    endgenerate

    assign out_valid = vld_q[DEPTH-1];
    assign out_sof   = sof_q[DEPTH-1];
    assign out_eol   = eol_q[DEPTH-1];

endmodule

// File: rtl/rgb2yuv_matrix_chk.sv
module rgb2yuv_matrix_chk #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 14,
    parameter int NREG   = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   in_sof,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [3*PIX_W-1:0]     out_pix,
    input logic                   out_sof,
    input logic                   out_eol,
    input logic [NREG*COEF_W-1:0] coef_act,
    input logic                   en_act,
    input logic                   pend
);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_sof) && $stable(out_eol)); // R3

    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R3

    AST_THREE_STAGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 out_ready ##1 out_ready |=> out_valid); // R2

    AST_BANK_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready && in_sof) |=> $stable(coef_act) && $stable(en_act)); // R9

    AST_PENDING_WAITS_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !(in_valid && in_ready && in_sof) |=> pend); // R9

endmodule

bind rgb2yuv_matrix rgb2yuv_matrix_chk #(
    .PIX_W  (PIX_W),
    .COEF_W (COEF_W),
    .NREG   (rgb2yuv_pkg::NREG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix),
    .out_sof   (out_sof),
    .out_eol   (out_eol),
    .coef_act  (coef_act),
    .en_act    (en_act),
    .pend      (cfg_pending)
);

// File: tb/rgb2yuv_matrix_tb.sv
`timescale 1ns/1ps
module rgb2yuv_matrix_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [13:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_pix = '0;
    logic        in_sof = 1'b0;
    logic        in_eol = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [23:0] out_pix;
    logic        out_sof;
    logic        out_eol;

    always #2 clk = ~clk;

    rgb2yuv_matrix u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
        .out_sof(out_sof), .out_eol(out_eol)
    );

    typedef struct {
        logic [23:0] pix;
        logic        sof;
        logic        eol;
        bit          lat;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit bp_on  = 1'b0;
    bit done   = 1'b0;
    int mdl_sh [13];
    int mdl_ac [13];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sx(input int v);
        return (v >= 8192) ? v - 16384 : v;
    endfunction

    function automatic logic [7:0] calc(input int row, input int r, input int g, input int b);
        int s;
        s = sx(mdl_ac[row*4]) * r + sx(mdl_ac[row*4+1]) * g +
            sx(mdl_ac[row*4+2]) * b + sx(mdl_ac[row*4+3]) * 64;
        s = s >>> 10;
        if (s < 0)   s = 0;
        if (s > 255) s = 255;
        return 8'(s);
    endfunction

    task automatic send(input int r, input int g, input int b,
                        input logic sof, input logic eol, input string tag);
        exp_t e;
        if (sof) for (int k = 0; k < 13; k++) mdl_ac[k] = mdl_sh[k];
        if (mdl_ac[12] != 0) e.pix = {calc(0, r, g, b), calc(1, r, g, b), calc(2, r, g, b)};
        else                 e.pix = {8'(r), 8'(g), 8'(b)};
        e.sof = sof; e.eol = eol; e.lat = !bp_on; e.tag = tag;
        in_valid = 1'b1; in_pix = {8'(r), 8'(g), 8'(b)}; in_sof = sof; in_eol = eol;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        e.cyc = cyc;
        q.push_back(e);
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
    endtask

    task automatic wr(input int addr, input int data);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 14'(data);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (addr < 12)       mdl_sh[addr] = data & 16'h3FFF;
        else if (addr == 12) mdl_sh[12]   = data & 1;
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic line(input int seed, input int n, input logic first_sof, input string tag);
        for (int i = 0; i < n; i++) begin
            send((seed + i * 37) % 256, (seed * 3 + i * 91) % 256, (seed * 7 + i * 53 + 11) % 256,
                 first_sof && i == 0, i == n - 1, tag);
        end
    endtask

    // backpressure pattern
    initial begin
        forever begin
            @(posedge clk); #1;
            out_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
        end
    end

    // monitor / scoreboard
    initial begin
        logic [23:0] held;
        bit          stalled;
        stalled = 1'b0;
        held    = '0;
        forever begin
            @(negedge clk);
            if (stalled) begin
                checks++;
                if (!(out_valid && out_pix == held)) begin
                    fails++;
                    $display("FAIL R3: stalled output act v=%0b %h exp v=1 %h", out_valid, out_pix, held);
                end
            end
            stalled = 1'b0;
            if (out_valid && !out_ready) begin
                stalled = 1'b1;
                held    = out_pix;
            end
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R3: unexpected output act %h exp none", out_pix);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    checks++;
                    if (out_pix !== e.pix || out_sof !== e.sof || out_eol !== e.eol) begin
                        fails++;
                        $display("FAIL %s/R10: act pix=%h sof=%0b eol=%0b exp pix=%h sof=%0b eol=%0b",
                                 e.tag, out_pix, out_sof, out_eol, e.pix, e.sof, e.eol);
                    end
                    if (e.lat) begin
                        checks++;
                        if (cyc - e.cyc != 3) begin
                            fails++;
                            $display("FAIL R2: latency act %0d exp 3", cyc - e.cyc);
                        end
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: act hung exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 12; k++) begin
            mdl_sh[k] = int'(rgb2yuv_pkg::reset_coef(k));
            mdl_ac[k] = mdl_sh[k];
        end
        mdl_sh[12] = 0; mdl_ac[12] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R1: reset act out_valid=%0b in_ready=%0b exp 0 1", out_valid, in_ready);
        end
        @(posedge clk); #1;

        // R1 / R4: enable clear after reset -> bypass
        send(12, 34, 56, 1'b1, 1'b0, "R1");
        send(200, 100, 0, 1'b0, 1'b0, "R4");
        send(255, 255, 255, 1'b0, 1'b1, "R4");

        // R9: enable written, not applied until next start-of-frame
        wr(12, 1);
        send(90, 80, 70, 1'b0, 1'b1, "R9");
        // R7 / R5: default matrix
        send(255, 255, 255, 1'b1, 1'b0, "R7");
        send(0, 0, 0, 1'b0, 1'b0, "R7");
        send(255, 0, 0, 1'b0, 1'b0, "R5");
        send(0, 255, 0, 1'b0, 1'b0, "R5");
        send(0, 0, 255, 1'b0, 1'b1, "R5");
        line(5, 8, 1'b0, "R5");
        drain();

        // R3: backpressure with streaming
        bp_on = 1'b1;
        line(17, 10, 1'b1, "R3");
        line(99, 10, 1'b0, "R3");
        drain();
        bp_on = 1'b0;
        drain();

        // R6 / R9: clamping rows written mid-frame
        wr(0, 16'h1FFF); wr(1, 16'h1FFF); wr(2, 16'h1FFF); wr(3, 0);
        wr(4, 16'h3C00); wr(5, 16'h3C00); wr(6, 16'h3C00); wr(7, 0);
        wr(8, 16'h0400); wr(9, 0); wr(10, 0); wr(11, 16'h0010);
        send(10, 20, 30, 1'b0, 1'b1, "R9");
        send(255, 255, 255, 1'b1, 1'b0, "R6");
        send(100, 1, 1, 1'b0, 1'b0, "R6");
        send(0, 0, 0, 1'b0, 1'b0, "R6");
        send(3, 200, 9, 1'b0, 1'b1, "R6");
        drain();

        // R8: unmapped addresses ignored
        wr(13, 0); wr(14, 16'h3FFF); wr(15, 16'h3FFF);
        send(255, 40, 40, 1'b1, 1'b0, "R8");
        send(100, 1, 1, 1'b0, 1'b1, "R8");
        drain();

        // R4: disable keeps coefficients; re-enable restores conversion
        wr(12, 0);
        send(100, 1, 1, 1'b1, 1'b1, "R4");
        wr(12, 1);
        send(100, 1, 1, 1'b1, 1'b1, "R4");
        // R9: write coinciding with nothing, then back-to-back frames
        wr(0, 16'h0107); wr(1, 16'h0204); wr(2, 16'h0064); wr(3, 16'h0108);
        line(44, 6, 1'b1, "R9");
        line(45, 6, 1'b1, "R10");
        drain();

        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R3: leftover act %0d exp 0", q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule